// File: doc/BRIEF.md
# Escape-Delimited Byte Frame Codec

This block packs and unpacks frames on a character-oriented serial link. The transmit half accepts payload bytes on a valid/ready stream. A marker on the stream flags the last byte of each frame. The block wraps each frame between an opening pair and a closing pair. Both pairs start with the escape code. Any payload byte that equals the escape code goes out twice, so the far end can tell data apart from delimiters. The outgoing byte stream has its own valid/ready handshake, and downstream backpressure reaches the payload input without loss.

The receive half watches an incoming byte stream, one byte per cycle when its valid is high. It locks onto the opening pair and removes the delimiters and the doubled escapes. It then delivers the original payload bytes, with a first marker on the opening byte of each frame and a last marker on the final one. To place the last marker, the receiver holds one byte back until it sees what follows. The receiver gives a one-cycle error pulse in two cases: an escape followed by an undefined code, and a new opening pair inside an open frame. In both cases it drops the byte it is still holding.

Codes are parameters: escape 0x10, start-of-frame 0x02, end-of-frame 0x03 by default.

Top module: `dle_frame_codec`

## Requirements
- R1: Every transmitted frame begins with the escape byte (0x10) followed by the start code (0x02), ahead of any payload byte.
- R2: After the payload byte marked last is accepted, the transmitter sends the escape byte and then the end code (0x03), and only then starts the next frame.
- R3: A payload byte equal to 0x10 goes out as two 0x10 bytes. In the cycle after such a byte is accepted, txInReady is low and txOutData is 0x10 with txOutValid high.
- R4: While txOutValid is high and txOutReady is low, the next cycle keeps txOutValid high and txOutData unchanged. No byte is lost or repeated under any backpressure pattern.
- R5: Within a frame the receiver outputs the payload bytes in order. Delimiters are removed, and each 0x10 0x10 pair yields a single 0x10. rxOutFirst is set on the first byte and rxOutLast on the final byte. A frame with no payload produces no output, and a last-marked output is never followed by another output in the next cycle.
- R6: Inside a frame, 0x10 followed by any code other than 0x10, 0x02 or 0x03 raises rxErrBadEsc for one cycle. The held byte is dropped, no last marker is given, and the input is ignored until the next 0x10 0x02.
- R7: Inside a frame, 0x10 0x02 raises rxErrAbort for one cycle and drops the held byte. The bytes that follow form a new frame whose first byte carries rxOutFirst.
- R8: Bytes received outside a frame produce no output and no error. This includes a 0x10 followed by a code other than 0x02.
- R9: After reset, txOutValid, txInReady, rxOutValid, rxErrBadEsc and rxErrAbort are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous reset, active low |
| txInData | input | 8 | Payload byte to send |
| txInValid | input | 1 | Payload byte is valid |
| txInLast | input | 1 | Payload byte ends its frame |
| txInReady | output | 1 | Payload byte accepted this cycle |
| txOutData | output | 8 | Encoded line byte |
| txOutValid | output | 1 | Line byte is valid |
| txOutReady | input | 1 | Line sink accepts the byte |
| rxInData | input | 8 | Received line byte |
| rxInValid | input | 1 | Received byte present |
| rxOutData | output | 8 | Decoded payload byte |
| rxOutValid | output | 1 | Decoded byte valid (one cycle) |
| rxOutFirst | output | 1 | Decoded byte opens a frame |
| rxOutLast | output | 1 | Decoded byte closes a frame |
| rxErrBadEsc | output | 1 | Undefined escape code pulse |
| rxErrAbort | output | 1 | Frame restarted while open pulse |

## Verification
The assertions check several properties on every cycle. The transmit output must hold steady under backpressure. The escape duplicate must follow an accepted escape byte, with ready low. The closing escape must follow the last payload byte. On the receive side, no decoded byte may coincide with an error pulse or directly follow a last marker. Only the bench scenarios can show the rest: whole encoded streams compared byte by byte against frames of plain, escape-heavy and single-byte payloads, with and without sink stalls. They also show the receive results after noise outside frames, empty frames, undefined escapes and restarts in mid-frame, where both what is delivered and what is dropped are checked.

// File: rtl/dle_codec_pkg.sv
package dle_codec_pkg;

  typedef enum logic [1:0] {
    SRC_ESC,
    SRC_SOF,
    SRC_EOF,
    SRC_PAY
  } txSrc_e;

  typedef struct packed {
    txSrc_e src;
    logic   captureLast;
  } txStrobe_t;

  typedef struct packed {
    logic pushByte;
    logic openFrame;
    logic closeFrame;
    logic dropFrame;
  } rxStrobe_t;

  typedef enum logic [2:0] {
    TX_IDLE,
    TX_HEAD_ESC,
    TX_HEAD_SOF,
    TX_BODY,
    TX_DUP,
    TX_TAIL_ESC,
    TX_TAIL_EOF
  } txState_e;

  typedef enum logic [1:0] {
    RX_HUNT,
    RX_HUNT_ESC,
    RX_BODY,
    RX_BODY_ESC
  } rxState_e;

endpackage

// File: rtl/dle_tx_ctrl.sv
module dle_tx_ctrl
  import dle_codec_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      inValid,
  input  logic      inLast,
  input  logic      outReady,
  input  logic      isEsc,
  input  logic      lastPend,
  output logic      inReady,
  output logic      outValid,
  output txStrobe_t strobe
);

  txState_e state, stateNext;

  always_ff @(posedge clk) begin
    if (!rstN) state <= TX_IDLE;
    else       state <= stateNext;
  end

  always_comb begin
    stateNext          = state;
    strobe.src         = SRC_ESC;
    strobe.captureLast = 1'b0;
    outValid           = 1'b0;
    inReady            = 1'b0;
    case (state)
      TX_IDLE: begin
        if (inValid) stateNext = TX_HEAD_ESC;
      end
      TX_HEAD_ESC: begin
        outValid = 1'b1;
        if (outReady) stateNext = TX_HEAD_SOF;
      end
      TX_HEAD_SOF: begin
        outValid   = 1'b1;
        strobe.src = SRC_SOF;
        if (outReady) stateNext = TX_BODY;
      end
      TX_BODY: begin
        strobe.src = SRC_PAY;
        outValid   = inValid;
        inReady    = outReady;
        if (inValid && outReady) begin
          if (isEsc) begin
            strobe.captureLast = 1'b1;
            stateNext          = TX_DUP;
          end else if (inLast) begin
            stateNext = TX_TAIL_ESC;
          end
        end
      end
      TX_DUP: begin
        outValid = 1'b1;
        if (outReady) stateNext = lastPend ? TX_TAIL_ESC : TX_BODY;
      end
      TX_TAIL_ESC: begin
        outValid = 1'b1;
        if (outReady) stateNext = TX_TAIL_EOF;
      end
      TX_TAIL_EOF: begin
        outValid   = 1'b1;
        strobe.src = SRC_EOF;
        if (outReady) stateNext = TX_IDLE;
      end
      default: stateNext = TX_IDLE;
    endcase
  end

endmodule

// File: rtl/dle_tx_path.sv
module dle_tx_path
  import dle_codec_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter logic [DATA_W-1:0] ESC_CODE = 8'h10,
  parameter logic [DATA_W-1:0] SOF_CODE = 8'h02,
  parameter logic [DATA_W-1:0] EOF_CODE = 8'h03
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [DATA_W-1:0] inData,
  input  logic              inLast,
  input  txStrobe_t         strobe,
  output logic [DATA_W-1:0] outData,
  output logic              isEsc,
  output logic              lastPend
);

  assign isEsc = (inData == ESC_CODE);

  always_ff @(posedge clk) begin
    if (!rstN)                   lastPend <= 1'b0;
    else if (strobe.captureLast) lastPend <= inLast;
  end

  always_comb begin
    case (strobe.src)
      SRC_SOF: outData = SOF_CODE;
      SRC_EOF: outData = EOF_CODE;
      SRC_PAY: outData = inData;
      default: outData = ESC_CODE;
    endcase
  end

endmodule

// File: rtl/dle_rx_ctrl.sv
module dle_rx_ctrl
  import dle_codec_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      inValid,
  input  logic      isEsc,
  input  logic      isSof,
  input  logic      isEof,
  output rxStrobe_t strobe,
  output logic      errBadEsc,
  output logic      errAbort
);

  rxState_e state, stateNext;
  logic     badNext, abortNext;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state     <= RX_HUNT;
      errBadEsc <= 1'b0;
      errAbort  <= 1'b0;
    end else begin
      state     <= stateNext;
      errBadEsc <= badNext;
      errAbort  <= abortNext;
    end
  end

  always_comb begin
    stateNext = state;
    strobe    = '0;
    badNext   = 1'b0;
    abortNext = 1'b0;
    if (inValid) begin
      case (state)
        RX_HUNT: begin
          if (isEsc) stateNext = RX_HUNT_ESC;
        end
        RX_HUNT_ESC: begin
          if (isSof) begin
            strobe.openFrame = 1'b1;
            stateNext        = RX_BODY;
          end else if (!isEsc) begin
            stateNext = RX_HUNT;
          end
        end
        RX_BODY: begin
          if (isEsc) stateNext = RX_BODY_ESC;
          else       strobe.pushByte = 1'b1;
        end
        RX_BODY_ESC: begin
          if (isEsc) begin
            strobe.pushByte = 1'b1;
            stateNext       = RX_BODY;
          end else if (isEof) begin
            strobe.closeFrame = 1'b1;
            stateNext         = RX_HUNT;
          end else if (isSof) begin
            strobe.dropFrame = 1'b1;
            strobe.openFrame = 1'b1;
            abortNext        = 1'b1;
            stateNext        = RX_BODY;
          end else begin
            strobe.dropFrame = 1'b1;
            badNext          = 1'b1;
            stateNext        = RX_HUNT;
          end
        end
        default: stateNext = RX_HUNT;
      endcase
    end
  end

endmodule

// File: rtl/dle_rx_path.sv
module dle_rx_path
  import dle_codec_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter logic [DATA_W-1:0] ESC_CODE = 8'h10,
  parameter logic [DATA_W-1:0] SOF_CODE = 8'h02,
  parameter logic [DATA_W-1:0] EOF_CODE = 8'h03
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [DATA_W-1:0] inData,
  input  rxStrobe_t         strobe,
  output logic              isEsc,
  output logic              isSof,
  output logic              isEof,
  output logic [DATA_W-1:0] outData,
  output logic              outValid,
  output logic              outFirst,
  output logic              outLast
);

  logic [DATA_W-1:0] holdData;
  logic              holdValid;
  logic              holdFirst;
  logic              firstPend;

  assign isEsc = (inData == ESC_CODE);
  assign isSof = (inData == SOF_CODE);
  assign isEof = (inData == EOF_CODE);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      holdData  <= '0;
      holdValid <= 1'b0;
      holdFirst <= 1'b0;
      firstPend <= 1'b0;
      outData   <= '0;
      outValid  <= 1'b0;
      outFirst  <= 1'b0;
      outLast   <= 1'b0;
    end else begin
      outValid <= 1'b0;
      outFirst <= 1'b0;
      outLast  <= 1'b0;
      if (strobe.dropFrame) begin
        holdValid <= 1'b0;
        firstPend <= 1'b0;
      end
      if (strobe.openFrame) begin
        holdValid <= 1'b0;
        firstPend <= 1'b1;
      end
      if (strobe.pushByte) begin
        if (holdValid) begin
          outData  <= holdData;
          outValid <= 1'b1;
          outFirst <= holdFirst;
        end
        holdData  <= inData;
        holdValid <= 1'b1;
        holdFirst <= firstPend;
        firstPend <= 1'b0;
      end
      if (strobe.closeFrame) begin
        if (holdValid) begin
          outData  <= holdData;
          outValid <= 1'b1;
          outFirst <= holdFirst;
          outLast  <= 1'b1;
        end
        holdValid <= 1'b0;
        firstPend <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/dle_frame_codec.sv
module dle_frame_codec
  import dle_codec_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter logic [DATA_W-1:0] ESC_CODE = 8'h10,
  parameter logic [DATA_W-1:0] SOF_CODE = 8'h02,
  parameter logic [DATA_W-1:0] EOF_CODE = 8'h03
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [DATA_W-1:0] txInData,
  input  logic              txInValid,
  input  logic              txInLast,
  output logic              txInReady,
  output logic [DATA_W-1:0] txOutData,
  output logic              txOutValid,
  input  logic              txOutReady,
  input  logic [DATA_W-1:0] rxInData,
  input  logic              rxInValid,
  output logic [DATA_W-1:0] rxOutData,
  output logic              rxOutValid,
  output logic              rxOutFirst,
  output logic              rxOutLast,
  output logic              rxErrBadEsc,
  output logic              rxErrAbort
);

  txStrobe_t txStrobe;
  rxStrobe_t rxStrobe;
  logic      txIsEsc, txLastPend;
  logic      rxIsEsc, rxIsSof, rxIsEof;

  dle_tx_ctrl uTxCtrl (
    .clk(clk), .rstN(rstN),
    .inValid(txInValid), .inLast(txInLast), .outReady(txOutReady),
    .isEsc(txIsEsc), .lastPend(txLastPend),
    .inReady(txInReady), .outValid(txOutValid), .strobe(txStrobe)
  );

  dle_tx_path #(.DATA_W(DATA_W), .ESC_CODE(ESC_CODE), .SOF_CODE(SOF_CODE), .EOF_CODE(EOF_CODE)) uTxPath (
    .clk(clk), .rstN(rstN),
    .inData(txInData), .inLast(txInLast), .strobe(txStrobe),
    .outData(txOutData), .isEsc(txIsEsc), .lastPend(txLastPend)
  );

  dle_rx_ctrl uRxCtrl (
    .clk(clk), .rstN(rstN),
    .inValid(rxInValid), .isEsc(rxIsEsc), .isSof(rxIsSof), .isEof(rxIsEof),
    .strobe(rxStrobe), .errBadEsc(rxErrBadEsc), .errAbort(rxErrAbort)
  );

  dle_rx_path #(.DATA_W(DATA_W), .ESC_CODE(ESC_CODE), .SOF_CODE(SOF_CODE), .EOF_CODE(EOF_CODE)) uRxPath (
    .clk(clk), .rstN(rstN),
    .inData(rxInData), .strobe(rxStrobe),
    .isEsc(rxIsEsc), .isSof(rxIsSof), .isEof(rxIsEof),
    .outData(rxOutData), .outValid(rxOutValid),
    .outFirst(rxOutFirst), .outLast(rxOutLast)
  );

  // Escape payload byte accepted: duplicate follows, input stalled
  assert_dup_escape_R3: assert property (@(posedge clk) disable iff (!rstN)
    (txInValid && txInReady && txInData == ESC_CODE)
      |=> (txOutValid && txOutData == ESC_CODE && !txInReady));

  // Last plain payload byte accepted: closing escape follows
  assert_close_after_last_R2: assert property (@(posedge clk) disable iff (!rstN)
    (txInValid && txInReady && txInLast && txInData != ESC_CODE)
      |=> (txOutValid && txOutData == ESC_CODE && !txInReady));

  // Stalled line byte stays put
  assert_hold_on_stall_R4: assert property (@(posedge clk) disable iff (!rstN)
    (txOutValid && !txOutReady) |=> (txOutValid && $stable(txOutData)));

  // Error pulses never carry a decoded byte (R6, R7)
  assert_err_no_output_R6: assert property (@(posedge clk) disable iff (!rstN)
    (rxErrBadEsc || rxErrAbort) |-> !rxOutValid);

  // Frame close is followed by a quiet cycle
  assert_gap_after_last_R5: assert property (@(posedge clk) disable iff (!rstN)
    (rxOutValid && rxOutLast) |=> !rxOutValid);

endmodule

// File: tb/dle_frame_codec_test.sv
module dle_frame_codec_test;
  localparam logic [7:0] ESC = 8'h10;
  localparam logic [7:0] SOF = 8'h02;
  localparam logic [7:0] EOF = 8'h03;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #10 clk = ~clk;

  logic [7:0] txInData = '0;
  logic       txInValid = 1'b0, txInLast = 1'b0, txInReady;
  logic [7:0] txOutData;
  logic       txOutValid, txOutReady = 1'b1;
  logic [7:0] rxInData = '0;
  logic       rxInValid = 1'b0;
  logic [7:0] rxOutData;
  logic       rxOutValid, rxOutFirst, rxOutLast, rxErrBadEsc, rxErrAbort;

  dle_frame_codec uut (
    .clk(clk), .rstN(rstN),
    .txInData(txInData), .txInValid(txInValid), .txInLast(txInLast), .txInReady(txInReady),
    .txOutData(txOutData), .txOutValid(txOutValid), .txOutReady(txOutReady),
    .rxInData(rxInData), .rxInValid(rxInValid),
    .rxOutData(rxOutData), .rxOutValid(rxOutValid), .rxOutFirst(rxOutFirst),
    .rxOutLast(rxOutLast), .rxErrBadEsc(rxErrBadEsc), .rxErrAbort(rxErrAbort)
  );

  int checks = 0, failures = 0;
  logic [7:0] txExp[$];
  logic [9:0] rxExp[$];
  logic [7:0] txPayload[$];
  int rxOutCount = 0, badSeen = 0, abortSeen = 0, readyCnt = 0;
  bit txPressure = 0, prevStall = 0, prevEscTaken = 0, done = 0;
  logic [7:0] prevData = '0;

  task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic finishRun();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  // line sink readiness pattern
  always @(posedge clk) begin
    #2;
    readyCnt++;
    txOutReady = txPressure ? ((readyCnt % 3) != 0) : 1'b1;
  end

  // transmit monitor
  always @(negedge clk) begin
    if (rstN) begin
      if (prevStall)
        check(txOutValid && txOutData == prevData, "R4", "stalled byte changed", txOutData, prevData);
      if (prevEscTaken)
        check(!txInReady && txOutValid && txOutData == ESC, "R3", "escape duplicate/ready", {txInReady, txOutData}, ESC);
      if (txOutValid && txOutReady) begin
        if (txExp.size() == 0) check(0, "R1", "unexpected line byte", txOutData, 0);
        else begin
          logic [7:0] e;
          e = txExp.pop_front();
          check(txOutData == e, "R1 R2 R3", "line byte", txOutData, e);
        end
      end
      prevStall    = txOutValid && !txOutReady;
      prevData     = txOutData;
      prevEscTaken = txInValid && txInReady && txInData == ESC;
    end
  end

  // receive monitor
  always @(negedge clk) begin
    if (rstN) begin
      if (rxErrBadEsc) badSeen++;
      if (rxErrAbort) abortSeen++;
      if (rxOutValid) begin
        rxOutCount++;
        if (rxExp.size() == 0) check(0, "R5 R8", "unexpected payload", {rxOutFirst, rxOutLast, rxOutData}, 0);
        else begin
          logic [9:0] e;
          e = rxExp.pop_front();
          check({rxOutFirst, rxOutLast, rxOutData} == e, "R5", "payload first/last/data",
                {rxOutFirst, rxOutLast, rxOutData}, e);
        end
      end
    end
  end

  task automatic sendFrame();
    int n;
    n = txPayload.size();
    txExp.push_back(ESC);
    txExp.push_back(SOF);
    foreach (txPayload[k]) begin
      txExp.push_back(txPayload[k]);
      if (txPayload[k] == ESC) txExp.push_back(ESC);
    end
    txExp.push_back(ESC);
    txExp.push_back(EOF);
    for (int i = 0; i < n; i++) begin
      bit hs;
      txInData = txPayload[i];
      txInValid = 1'b1;
      txInLast = (i == n - 1);
      do begin
        @(negedge clk);
        hs = txInReady;
        @(posedge clk);
        #2;
      end while (!hs);
    end
    txInValid = 1'b0;
    txInLast = 1'b0;
  endtask

  task automatic drainTx();
    for (int i = 0; i < 200 && txExp.size() != 0; i++) @(posedge clk);
    repeat (2) @(posedge clk);
    #2;
    check(txExp.size() == 0, "R2", "frame not fully sent", txExp.size(), 0);
  endtask

  task automatic rxSend(input logic [7:0] b);
    rxInData = b;
    rxInValid = 1'b1;
    @(posedge clk);
    #2;
    rxInValid = 1'b0;
  endtask

  task automatic rxIdle(input int n);
    rxInValid = 1'b0;
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic rxExpect(input bit f, input bit l, input logic [7:0] d);
    rxExp.push_back({f, l, d});
  endtask

  task automatic rxSettle(input string req);
    rxIdle(3);
    check(rxExp.size() == 0, req, "payload missing", rxExp.size(), 0);
  endtask

  initial begin
    #(20 * 150000);
    if (!done) begin
      check(0, "R1", "watchdog expired", 0, 1);
      finishRun();
    end
  end

  initial begin
    int cnt0, bad0, ab0;
    repeat (4) @(posedge clk);
    #2;
    rstN = 1'b1;
    @(negedge clk);
    check(!txOutValid, "R9", "txOutValid after reset", txOutValid, 0);
    check(!txInReady, "R9", "txInReady after reset", txInReady, 0);
    check(!rxOutValid, "R9", "rxOutValid after reset", rxOutValid, 0);
    check(!rxErrBadEsc && !rxErrAbort, "R9", "error flags after reset", {rxErrBadEsc, rxErrAbort}, 0);
    @(posedge clk);
    #2;

    // transmit: plain, lone escape, escape-heavy, end-code payload
    txPayload = '{8'h41, 8'h42, 8'h43};              sendFrame();
    txPayload = '{8'h10};                            sendFrame();
    txPayload = '{8'h10, 8'h10, 8'h55, 8'h10};       sendFrame();
    txPayload = '{8'h03};                            sendFrame();
    drainTx();
    // same under sink stalls (R4)
    txPressure = 1;
    txPayload = '{8'h10, 8'h02, 8'h10, 8'h7f};       sendFrame();
    txPayload = '{8'h11, 8'h22, 8'h33, 8'h44, 8'h10}; sendFrame();
    drainTx();
    txPressure = 0;

    // receive R8: noise outside frames
    cnt0 = rxOutCount;
    rxSend(8'h55); rxSend(8'h03); rxSend(8'h02); rxSend(8'h10); rxSend(8'h41); rxSend(8'h10); rxSend(8'h03);
    rxIdle(3);
    check(rxOutCount == cnt0, "R8", "output from noise", rxOutCount - cnt0, 0);
    check(badSeen == 0 && abortSeen == 0, "R8", "error from noise", badSeen + abortSeen, 0);

    // R5 normal frame with doubled escape and an idle gap
    rxExpect(1, 0, 8'h41); rxExpect(0, 0, 8'h10); rxExpect(0, 1, 8'h42);
    rxSend(ESC); rxSend(SOF); rxSend(8'h41); rxIdle(2); rxSend(ESC); rxSend(ESC); rxSend(8'h42);
    rxSend(ESC); rxSend(EOF);
    rxSettle("R5");
    // R5 single byte and empty frame
    rxExpect(1, 1, 8'h99);
    rxSend(ESC); rxSend(SOF); rxSend(8'h99); rxSend(ESC); rxSend(EOF);
    cnt0 = rxOutCount;
    rxSend(ESC); rxSend(SOF); rxSend(ESC); rxSend(EOF);
    rxSettle("R5");
    check(rxOutCount == cnt0 + 1, "R5", "empty frame output", rxOutCount - cnt0, 1);

    // R6 undefined escape
    bad0 = badSeen;
    rxExpect(1, 0, 8'h11);
    rxSend(ESC); rxSend(SOF); rxSend(8'h11); rxSend(8'h22); rxSend(ESC); rxSend(8'h55);
    cnt0 = rxOutCount;
    rxSend(8'h33); rxSend(ESC); rxSend(EOF);
    rxSettle("R6");
    check(badSeen == bad0 + 1, "R6", "bad escape pulses", badSeen - bad0, 1);
    check(rxOutCount == cnt0, "R6", "output after bad escape", rxOutCount - cnt0, 0);

    // R7 restart inside a frame
    ab0 = abortSeen;
    rxExpect(1, 0, 8'h61); rxExpect(1, 0, 8'h71); rxExpect(0, 1, 8'h72);
    rxSend(ESC); rxSend(SOF); rxSend(8'h61); rxSend(8'h62); rxSend(ESC); rxSend(SOF);
    rxSend(8'h71); rxSend(8'h72); rxSend(ESC); rxSend(EOF);
    rxSettle("R7");
    check(abortSeen == ab0 + 1, "R7", "abort pulses", abortSeen - ab0, 1);
    check(badSeen == bad0 + 1, "R7", "spurious bad escape", badSeen - bad0, 1);

    done = 1;
    finishRun();
  end

endmodule